// File: doc/BRIEF.md
# Reset-Guarded Host RAM with Halt Mode

This block wraps a single-clock RAM behind a 16-bit host bus and a configuration register. The host reaches the array with byte and half-word transfers; a 32-bit word is stored as two consecutive half-word cycles, upper half first, at a 4-byte-aligned address and the address two above it. The top address bit selects the configuration register instead of the array. Every transfer is captured in one cycle, executed in the next, and answered with a one-cycle ready pulse that carries an error flag and read data.

A synchronous reset request (`sreset_req_i`) lets any array write already captured finish normally. After that it latches a write inhibit that blocks every later array write until the full asynchronous reset `rst_ni` is applied. Because the two halves of a word are separate cycles, a request that lands during the first half leaves a torn word. The register holds a halt bit. While it is set, the array refuses all reads and writes but keeps its contents. The register stays writable so that the halt bit can be cleared.

Top module: `guard_ram`

## Requirements
- R1: While and after `rst_ni` is low, `rsp_ready_o` and `rsp_error_o` are 0, the halt bit is 0, the attribute field holds `ATTR_RST`, the write inhibit is clear, and a register read returns 0x0000 with the default parameters.
- R2: A request held valid on an idle bus is captured at the next rising edge. `rsp_ready_o` is high for exactly the cycle after the following edge, and nothing new is captured while ready is high.
- R3: The array is big-endian over 16-bit entries. A byte access with address bit 0 = 0 uses lane [15:8], and with bit 0 = 1 it uses lane [7:0], taking write data from that same lane. A half-word access ignores address bit 0. Reads always return the whole 16-bit entry.
- R4: A 32-bit word written as a half-word at a 4-aligned address A (upper half) followed by one at A+2 (lower half) reads back as those two halves.
- R5: A synchronous reset request that arrives after an array write was captured, before it executes, lets that write store its data and answer without error.
- R6: Once a request has been seen, every later array write answers with error and leaves the array unchanged, while array reads still answer without error.
- R7: A request during the first half of a word write stores the new upper half; the second half answers with error, so the word holds the new upper and the old lower half.
- R8: A request during the second half of a word write leaves the complete new word stored.
- R9: With the halt bit set, array reads and writes answer with error and read data 0x0000, and the contents are retained once the bit is cleared.
- R10: The register lies at any address with bit 9 set (ADDR_W = 10). The halt bit is bit 0 and the attribute field is bits [11:8]. While halted, the register remains writable, reads as 0x0001, and writing 0 to bit 0 restores array access.
- R11: Attribute writes are ignored while halted and in any write that changes the halt bit.
- R12: A synchronous reset request clears the halt bit and keeps the attribute field. The inhibit stays set until `rst_ni`, which clears it and restores the register defaults.
- R13: A request in the same cycle as an array write is captured counts before it, so that write answers with error and stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low full module reset |
| sreset_req_i | input | 1 | Synchronous reset request, sampled each edge |
| req_valid_i | input | 1 | Transfer request, held until ready |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 1 | 1 = half-word, 0 = byte |
| req_addr_i | input | ADDR_W | Byte address; top bit selects the register |
| req_wdata_i | input | 16 | Write data |
| rsp_ready_o | output | 1 | One-cycle completion pulse |
| rsp_error_o | output | 1 | Transfer refused, valid with ready |
| rsp_rdata_o | output | 16 | Read data, valid with ready |

## Verification
The reset request and an array write can land in the same cycle in two ways. The request can arrive in the capture cycle, or it can arrive in the execute cycle of a write that is already captured. The bench provokes both by raising `sreset_req_i` one negative edge apart relative to the request. It judges the outcome from the error flag and by reading the location back. A second overlap is the request arriving while the halt bit is set, which is judged by reading the register back.

// File: rtl/guard_ram_pkg.sv
`timescale 1ns/1ps
package guard_ram_pkg;
  localparam int BUS_W = 16;
  localparam int LANES = BUS_W / 8;
  localparam int HALT_BIT = 0;
  localparam int ATTR_LSB = 8;

  typedef enum logic {SZ_BYTE = 1'b0, SZ_HALF = 1'b1} xfer_size_e;

  typedef struct packed {
    logic       write;
    xfer_size_e size;
    logic       reg_sel;
    logic       blocked;
  } xfer_flags_t;

  // bit 1 = lane [15:8], bit 0 = lane [7:0]
  function automatic logic [LANES-1:0] lane_en(xfer_size_e sz, logic a0);
    if (sz == SZ_HALF) return '1;
    return a0 ? 2'b01 : 2'b10;
  endfunction
endpackage

// File: rtl/guard_ram_bus.sv
`timescale 1ns/1ps
module guard_ram_bus
  import guard_ram_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  xfer_flags_t       req_flags_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [BUS_W-1:0]  req_wdata_i,
  output logic              accept_o,
  output logic              exec_o,
  output xfer_flags_t       x_flags_o,
  output logic [AW-1:0]     x_addr_o,
  output logic [BUS_W-1:0]  x_wdata_o,
  output logic              ready_o
);
  logic busy_q, ready_q;

  assign accept_o = req_valid_i && !busy_q && !ready_q;
  assign exec_o   = busy_q;
  assign ready_o  = ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      busy_q  <= accept_o;
      ready_q <= busy_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_flags_o <= '0;
      x_addr_o  <= '0;
      x_wdata_o <= '0;
    end else if (accept_o) begin
      x_flags_o <= req_flags_i;
      x_addr_o  <= req_addr_i;
      x_wdata_o <= req_wdata_i;
    end
  end

  assert_ready_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q |=> !ready_q);
  assert_ready_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_q && !ready_q) |=> ##1 ready_q);
endmodule

// File: rtl/guard_ram_ctrl.sv
`timescale 1ns/1ps
module guard_ram_ctrl
  import guard_ram_pkg::*;
#(
  parameter int              ATTR_W   = 4,
  parameter logic [ATTR_W-1:0] ATTR_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sreq_i,
  input  logic              wr_i,
  input  logic [LANES-1:0]  lanes_i,
  input  logic              halt_wd_i,
  input  logic [ATTR_W-1:0] attr_wd_i,
  output logic              halt_o,
  output logic              inhibit_o,
  output logic [BUS_W-1:0]  rdata_o
);
  logic              halt_q, inhibit_q;
  logic [ATTR_W-1:0] attr_q;
  logic              halt_wr, halt_change, attr_wr;

  assign halt_wr     = wr_i && lanes_i[0];
  assign halt_change = halt_wr && (halt_wd_i != halt_q);
  assign attr_wr     = wr_i && lanes_i[1] && !halt_q && !halt_change;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q    <= 1'b0;
      inhibit_q <= 1'b0;
      attr_q    <= ATTR_RST;
    end else begin
      if (sreq_i) inhibit_q <= 1'b1;
      if (sreq_i) halt_q <= 1'b0;
      else if (halt_wr) halt_q <= halt_wd_i;
      if (attr_wr) attr_q <= attr_wd_i;
    end
  end

  always_comb begin
    rdata_o           = '0;
    rdata_o[HALT_BIT] = halt_q;
    if (!halt_q) rdata_o[ATTR_LSB +: ATTR_W] = attr_q;
  end

  assign halt_o    = halt_q;
  assign inhibit_o = inhibit_q;

  assert_inhibit_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_q |=> inhibit_q);
  assert_sreq_clears_halt_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sreq_i |=> !halt_q);
  assert_attr_frozen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q |=> $stable(attr_q));
endmodule

// File: rtl/guard_ram_store.sv
`timescale 1ns/1ps
module guard_ram_store
  import guard_ram_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [LANES-1:0] lanes_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << IDX_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && lanes_i[l]) lane_mem[idx_i] <= wdata_i[8*l +: 8];
    end
    assign rdata_o[8*l +: 8] = lane_mem[idx_i];
  end
endmodule

// File: rtl/guard_ram.sv
`timescale 1ns/1ps
module guard_ram
  import guard_ram_pkg::*;
#(
  parameter int              ADDR_W   = 10,
  parameter int              ATTR_W   = 4,
  parameter logic [ATTR_W-1:0] ATTR_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sreset_req_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_size_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [15:0]       req_wdata_i,
  output logic              rsp_ready_o,
  output logic              rsp_error_o,
  output logic [15:0]       rsp_rdata_o
);
  localparam int AW    = ADDR_W - 1;
  localparam int IDX_W = ADDR_W - 2;

  logic              req_reg, halt, inhibit, accept, exec;
  xfer_flags_t       req_flags, x_flags;
  logic [AW-1:0]     x_addr;
  logic [BUS_W-1:0]  x_wdata, reg_rd, arr_rd;
  logic [LANES-1:0]  lanes;
  logic              array_we, reg_wr;
  logic              err_q;
  logic [BUS_W-1:0]  data_q;

  assign req_reg = req_addr_i[ADDR_W-1];

  always_comb begin
    req_flags.write   = req_write_i;
    req_flags.size    = xfer_size_e'(req_size_i);
    req_flags.reg_sel = req_reg;
    // a request seen at capture time counts before the access
    req_flags.blocked = !req_reg &&
                        (halt || (req_write_i && (inhibit || sreset_req_i)));
  end

  guard_ram_bus #(.AW(AW)) u_bus (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_flags_i (req_flags),
    .req_addr_i  (req_addr_i[AW-1:0]),
    .req_wdata_i (req_wdata_i),
    .accept_o    (accept),
    .exec_o      (exec),
    .x_flags_o   (x_flags),
    .x_addr_o    (x_addr),
    .x_wdata_o   (x_wdata),
    .ready_o     (rsp_ready_o)
  );

  assign lanes    = lane_en(x_flags.size, x_addr[0]);
  assign array_we = exec && x_flags.write && !x_flags.reg_sel && !x_flags.blocked;
  assign reg_wr   = exec && x_flags.write && x_flags.reg_sel;

  guard_ram_ctrl #(.ATTR_W(ATTR_W), .ATTR_RST(ATTR_RST)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sreq_i    (sreset_req_i),
    .wr_i      (reg_wr),
    .lanes_i   (lanes),
    .halt_wd_i (x_wdata[HALT_BIT]),
    .attr_wd_i (x_wdata[ATTR_LSB +: ATTR_W]),
    .halt_o    (halt),
    .inhibit_o (inhibit),
    .rdata_o   (reg_rd)
  );

  guard_ram_store #(.IDX_W(IDX_W)) u_store (
    .clk_i   (clk_i),
    .we_i    (array_we),
    .lanes_i (lanes),
    .idx_i   (x_addr[AW-1:1]),
    .wdata_i (x_wdata),
    .rdata_o (arr_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      data_q <= '0;
    end else begin
      err_q  <= exec && x_flags.blocked;
      data_q <= '0;
      if (exec && !x_flags.blocked && !x_flags.write)
        data_q <= x_flags.reg_sel ? reg_rd : arr_rd;
    end
  end

  assign rsp_error_o = err_q;
  assign rsp_rdata_o = data_q;

  assert_inflight_write_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && sreset_req_i && x_flags.write && !x_flags.reg_sel && !x_flags.blocked)
      |=> (rsp_ready_o && !rsp_error_o));
  assert_inhibit_refuses_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inhibit && accept && req_write_i && !req_reg) |=> ##1 (rsp_ready_o && rsp_error_o));
  assert_halt_refuses_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt && accept && !req_reg) |=> ##1 (rsp_error_o && rsp_rdata_o == '0));
  assert_capture_cycle_req_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sreset_req_i && accept && req_write_i && !req_reg) |=> ##1 rsp_error_o);
endmodule

// File: tb/guard_ram_bench.sv
`timescale 1ns/1ps
module guard_ram_bench;
  localparam logic [9:0] REG_A = 10'h200;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sreq = 1'b0;
  logic        valid = 1'b0, wr = 1'b0, half = 1'b0;
  logic [9:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        ready, err;
  logic [15:0] rdata;
  int          n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  guard_ram u_guard_ram (
    .clk_i(clk), .rst_ni(rst_ni), .sreset_req_i(sreq),
    .req_valid_i(valid), .req_write_i(wr), .req_size_i(half),
    .req_addr_i(addr), .req_wdata_i(wdata),
    .rsp_ready_o(ready), .rsp_error_o(err), .rsp_rdata_o(rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // sq: 0 none, 1 request in capture cycle, 2 request in execute cycle
  task automatic xfer(input logic w, input logic h, input logic [9:0] a,
                      input logic [15:0] d, input int sq,
                      output logic [15:0] rd, output logic er);
    valid = 1'b1; wr = w; half = h; addr = a; wdata = d;
    if (sq == 1) sreq = 1'b1;
    @(negedge clk);
    sreq = 1'b0;
    if (sq == 2) sreq = 1'b1;
    chk("R2 ready early", ready, 0);
    @(negedge clk);
    sreq = 1'b0;
    chk("R2 ready latency", ready, 1);
    rd = rdata; er = err;
    valid = 1'b0;
    @(negedge clk);
    chk("R2 ready single", ready, 0);
  endtask

  task automatic do_wr(input logic [9:0] a, input logic [15:0] d, input logic h,
                       input int sq, input logic exp_err, input string tag);
    logic [15:0] rd; logic er;
    xfer(1'b1, h, a, d, sq, rd, er);
    chk({tag, " write error"}, er, exp_err);
  endtask

  task automatic do_rd(input logic [9:0] a, input logic [15:0] exp,
                       input logic exp_err, input string tag);
    logic [15:0] rd; logic er;
    xfer(1'b0, 1'b1, a, 16'h0, 0, rd, er);
    chk({tag, " read error"}, er, exp_err);
    chk({tag, " read data"}, rd, exp);
  endtask

  task automatic full_reset();
    rst_ni = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_sreq();
    sreq = 1'b1;
    @(negedge clk);
    sreq = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 ready in reset", ready, 0);
    chk("R1 error in reset", err, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    do_rd(REG_A, 16'h0000, 1'b0, "R1 register default");
    do_wr(10'h008, 16'h1357, 1'b1, 0, 1'b0, "R1 write allowed");
  endtask

  task automatic t_lanes();
    do_wr(10'h010, 16'hA1B2, 1'b1, 0, 1'b0, "R3 half");
    do_wr(10'h010, 16'hC3EE, 1'b0, 0, 1'b0, "R3 upper byte");
    do_wr(10'h011, 16'hEED4, 1'b0, 0, 1'b0, "R3 lower byte");
    do_rd(10'h010, 16'hC3D4, 1'b0, "R3 lanes");
    do_rd(10'h011, 16'hC3D4, 1'b0, "R3 bit0 ignored");
  endtask

  task automatic t_word();
    do_wr(10'h020, 16'h1234, 1'b1, 0, 1'b0, "R4 upper");
    do_wr(10'h022, 16'h5678, 1'b1, 0, 1'b0, "R4 lower");
    do_rd(10'h020, 16'h1234, 1'b0, "R4 upper");
    do_rd(10'h022, 16'h5678, 1'b0, "R4 lower");
  endtask

  task automatic t_inflight();
    do_wr(10'h030, 16'h1111, 1'b1, 0, 1'b0, "R5 preload");
    do_wr(10'h032, 16'h2222, 1'b1, 0, 1'b0, "R6 preload");
    do_wr(10'h030, 16'hBEEF, 1'b1, 2, 1'b0, "R5 in-flight");
    do_rd(10'h030, 16'hBEEF, 1'b0, "R5 stored / R6 read ok");
    do_wr(10'h032, 16'h7777, 1'b1, 0, 1'b1, "R6 inhibited");
    do_wr(10'h033, 16'h0077, 1'b0, 0, 1'b1, "R6 inhibited byte");
    do_rd(10'h032, 16'h2222, 1'b0, "R6 unchanged");
    full_reset();
  endtask

  task automatic t_capture_cycle();
    do_wr(10'h034, 16'h3333, 1'b1, 0, 1'b0, "R13 preload");
    do_wr(10'h034, 16'h9999, 1'b1, 1, 1'b1, "R13 same cycle");
    do_rd(10'h034, 16'h3333, 1'b0, "R13 unchanged");
    full_reset();
  endtask

  task automatic t_torn();
    do_wr(10'h040, 16'hAAAA, 1'b1, 0, 1'b0, "R7 preload hi");
    do_wr(10'h042, 16'hBBBB, 1'b1, 0, 1'b0, "R7 preload lo");
    do_wr(10'h040, 16'hCCCC, 1'b1, 2, 1'b0, "R7 first half");
    do_wr(10'h042, 16'hDDDD, 1'b1, 0, 1'b1, "R7 second half");
    do_rd(10'h040, 16'hCCCC, 1'b0, "R7 new upper");
    do_rd(10'h042, 16'hBBBB, 1'b0, "R7 old lower");
    full_reset();
  endtask

  task automatic t_coherent();
    do_wr(10'h044, 16'h1357, 1'b1, 0, 1'b0, "R8 preload hi");
    do_wr(10'h046, 16'h2468, 1'b1, 0, 1'b0, "R8 preload lo");
    do_wr(10'h044, 16'hFEDC, 1'b1, 0, 1'b0, "R8 first half");
    do_wr(10'h046, 16'hBA98, 1'b1, 2, 1'b0, "R8 second half");
    do_rd(10'h044, 16'hFEDC, 1'b0, "R8 upper");
    do_rd(10'h046, 16'hBA98, 1'b0, "R8 lower");
    full_reset();
  endtask

  task automatic t_halt();
    do_wr(10'h050, 16'h5A5A, 1'b1, 0, 1'b0, "R9 preload");
    do_wr(REG_A, 16'h0500, 1'b1, 0, 1'b0, "R10 attr write");
    do_rd(REG_A, 16'h0500, 1'b0, "R10 attr read");
    do_wr(REG_A, 16'h0001, 1'b1, 0, 1'b0, "R11 set halt");
    do_rd(REG_A, 16'h0001, 1'b0, "R10 halted view");
    do_rd(10'h050, 16'h0000, 1'b1, "R9 halted read");
    do_wr(10'h050, 16'hFFFF, 1'b1, 0, 1'b1, "R9 halted write");
    do_wr(REG_A, 16'h0F01, 1'b1, 0, 1'b0, "R11 attr while halted");
    do_wr(REG_A, 16'h0900, 1'b1, 0, 1'b0, "R11 clear halt with attr");
    do_rd(REG_A, 16'h0500, 1'b0, "R11 attr kept");
    do_rd(10'h050, 16'h5A5A, 1'b0, "R9 retained");
  endtask

  task automatic t_sreq_halt();
    do_wr(REG_A, 16'h0001, 1'b1, 0, 1'b0, "R12 set halt");
    pulse_sreq();
    do_rd(REG_A, 16'h0500, 1'b0, "R12 halt cleared attr kept");
    do_wr(10'h060, 16'h4242, 1'b1, 0, 1'b1, "R12 inhibit persists");
    full_reset();
    do_rd(REG_A, 16'h0000, 1'b0, "R12 defaults restored");
    do_wr(10'h060, 16'h4242, 1'b1, 0, 1'b0, "R12 inhibit cleared");
    do_rd(10'h060, 16'h4242, 1'b0, "R12 write lands");
  endtask

  initial begin
    t_reset();
    t_lanes();
    t_word();
    t_inflight();
    t_capture_cycle();
    t_torn();
    t_coherent();
    t_halt();
    t_sreq_halt();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule